// File: doc/BRIEF.md
# Programmable Time-Tag Counter

This block is a free-running 16-bit time-stamp counter for a serial-bus remote terminal. Each message the terminal handles can be stamped with `count_o`. The count advances on a tick. A 3-bit select input picks the tick source: one of six rates divided down from the master clock, or the rising edges of an asynchronous external clock. The external clock passes through a synchronizer before it is used.

A command decoder outside this block reports each synchronize mode command as a one-cycle strobe. If that strobe also carries a data word, it is presented with a qualifier. When resynchronization is enabled, the strobe clears the count, or it loads the received word. The block raises two one-cycle interrupt pulses: one when the count wraps, and one when the count first reaches a host-written utility value. Each pulse has its own enable.

Top module: `tt_counter`

## Requirements
- R1: After reset is released, `count_o` reads 0 and both `roll_irq_o` and `match_irq_o` read 0.
- R2: With `rate_sel_i` = k for k in 0..5, the count advances by one once every BASE_DIV·2^k master cycles. With BASE_DIV = 100 and a 50 MHz clock, these tick periods are 2, 4, 8, 16, 32 and 64 µs. The phase of the divider runs freely from reset.
- R3: With `rate_sel_i` = 6, which is reserved, the count never advances.
- R4: With `rate_sel_i` = 7, the count advances once for each rising edge of `ext_clk_i`. The change shows on the third rising edge of `clk_i` after the input goes high. A high level that lasts at least one clock cycle is one edge.
- R5: When `sync_en_i` and `sync_i` are both high and `sync_data_vld_i` is low, the count becomes 0 on the next clock edge.
- R6: When `sync_en_i`, `sync_i` and `sync_data_vld_i` are all high, the count becomes `sync_data_i` on the next clock edge.
- R7: A load from R5 or R6 takes priority over a tick that falls in the same cycle. That tick is lost.
- R8: While `sync_en_i` is low, `sync_i` has no effect on the count.
- R9: When a tick moves the count from 0xFFFF to 0, the count wraps. If `roll_irq_en_i` is set at that edge, `roll_irq_o` is high for exactly the one cycle in which `count_o` first reads 0. A load to 0 never raises it.
- R10: Call c a cycle in which `count_o` equals `util_i` and in which it did not equal `util_i` in the cycle before. Reset counts as a cycle in which the two were equal. If `match_irq_en_i` is set in cycle c, `match_irq_o` is high for the single cycle c+1. It does not repeat while the two stay equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_sel_i | input | 3 | Tick source: 0..5 internal rates, 6 none, 7 external |
| ext_clk_i | input | 1 | Asynchronous external tick clock |
| sync_en_i | input | 1 | Enables resynchronization on sync commands |
| sync_i | input | 1 | One-cycle strobe for a sync mode command |
| sync_data_vld_i | input | 1 | The strobe carries a data word |
| sync_data_i | input | 16 | Data word to load |
| util_i | input | 16 | Compare value |
| roll_irq_en_i | input | 1 | Enable for the rollover pulse |
| match_irq_en_i | input | 1 | Enable for the match pulse |
| count_o | output | 16 | Current time-tag count |
| roll_irq_o | output | 1 | Rollover interrupt pulse |
| match_irq_o | output | 1 | Compare-match interrupt pulse |

## Verification
The assertions assume that every input except `ext_clk_i` is synchronous to `clk_i` and settles well before each edge. They also assume that a load request is a deliberate strobe and that the count is never forced by any other path. The bench changes every input, including `ext_clk_i`, only on falling clock edges. This keeps the synchronizer latency exact, so a cycle-accurate reference model can predict it. The bench shortens the divider base so that every internal rate and the 16-bit wrap fit into a short run, and it enters the wrap through a sync load near 0xFFFF.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int unsigned N_RATES = 6;
  localparam int unsigned SEL_W   = 3;
  localparam logic [SEL_W-1:0] SEL_EXT = 3'd7;
endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
  parameter int unsigned BASE_DIV = 100,
  parameter int unsigned N_RATES  = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [N_RATES-1:0] rate_tick_o
);
  localparam int unsigned DIV_W = (BASE_DIV > 2) ? $clog2(BASE_DIV) : 1;
  localparam int unsigned PRE_W = (N_RATES > 1) ? N_RATES - 1 : 1;

  logic [DIV_W-1:0] div_q;
  logic [PRE_W-1:0] pre_q;
  logic             base_tick;

  assign base_tick = (div_q == DIV_W'(BASE_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      pre_q <= '0;
    end else begin
      div_q <= base_tick ? '0 : div_q + 1'b1;
      if (base_tick) pre_q <= pre_q + 1'b1;
    end
  end

  // rate k: base tick when the low k bits of the base-tick count are all ones
  for (genvar k = 0; k < N_RATES; k++) begin : g_rate
    if (k == 0) begin : g_base
      assign rate_tick_o[k] = base_tick;
    end else begin : g_div
      assign rate_tick_o[k] = base_tick & (&pre_q[k-1:0]);
    end
  end
endmodule

// File: rtl/tt_edge_sync.sv
module tt_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tt_tick_mux.sv
module tt_tick_mux
  import tt_pkg::*;
#(
  parameter int unsigned NR = N_RATES
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [NR-1:0]    rate_tick_i,
  input  logic             ext_rise_i,
  output logic             tick_o
);
  always_comb begin
    tick_o = 1'b0;
    for (int k = 0; k < NR; k++) begin
      if (sel_i == SEL_W'(k)) tick_o = rate_tick_i[k];
    end
    if (sel_i == SEL_EXT) tick_o = ext_rise_i;
  end
endmodule

// File: rtl/tt_counter.sv
module tt_counter
  import tt_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned BASE_DIV    = 100,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] rate_sel_i,
  input  logic             ext_clk_i,
  input  logic             sync_en_i,
  input  logic             sync_i,
  input  logic             sync_data_vld_i,
  input  logic [CNT_W-1:0] sync_data_i,
  input  logic [CNT_W-1:0] util_i,
  input  logic             roll_irq_en_i,
  input  logic             match_irq_en_i,
  output logic [CNT_W-1:0] count_o,
  output logic             roll_irq_o,
  output logic             match_irq_o
);
  logic [N_RATES-1:0] rate_tick;
  logic               ext_rise;
  logic               tick;
  logic               load;
  logic               at_max;
  logic               eq_now;
  logic [CNT_W-1:0]   cnt_q;
  logic               eq_q;
  logic               roll_q;
  logic               match_q;

  tt_prescaler #(.BASE_DIV(BASE_DIV), .N_RATES(N_RATES)) u_pre (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rate_tick_o (rate_tick)
  );

  tt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (ext_clk_i),
    .rise_o  (ext_rise)
  );

  tt_tick_mux #(.NR(N_RATES)) u_mux (
    .sel_i       (rate_sel_i),
    .rate_tick_i (rate_tick),
    .ext_rise_i  (ext_rise),
    .tick_o      (tick)
  );

  assign load   = sync_en_i & sync_i;
  assign at_max = &cnt_q;
  assign eq_now = (cnt_q == util_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      eq_q    <= 1'b1;  // reset state counts as already equal
      roll_q  <= 1'b0;
      match_q <= 1'b0;
    end else begin
      if (load)      cnt_q <= sync_data_vld_i ? sync_data_i : '0;
      else if (tick) cnt_q <= cnt_q + 1'b1;
      roll_q  <= roll_irq_en_i & ~load & tick & at_max;
      eq_q    <= eq_now;
      match_q <= match_irq_en_i & eq_now & ~eq_q;
    end
  end

  assign count_o     = cnt_q;
  assign roll_irq_o  = roll_q;
  assign match_irq_o = match_q;
endmodule

// File: rtl/tt_counter_checker.sv
module tt_counter_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       rate_sel_i,
  input logic             sync_en_i,
  input logic             sync_i,
  input logic             sync_data_vld_i,
  input logic [CNT_W-1:0] sync_data_i,
  input logic [CNT_W-1:0] util_i,
  input logic [CNT_W-1:0] count_o,
  input logic             roll_irq_o,
  input logic             match_irq_o
);
  assert_step_by_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sync_en_i && sync_i) |=>
      (count_o == $past(count_o) || count_o == CNT_W'($past(count_o) + 1'b1)));

  assert_reserved_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_sel_i == 3'd6 && !(sync_en_i && sync_i)) |=> $stable(count_o));

  assert_sync_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_en_i && sync_i && !sync_data_vld_i) |=> (count_o == '0));

  assert_sync_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_en_i && sync_i && sync_data_vld_i) |=> (count_o == $past(sync_data_i)));

  assert_sync_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_en_i && sync_i && rate_sel_i == 3'd6) |=> $stable(count_o));

  assert_roll_at_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    roll_irq_o |-> (count_o == '0 && $past(count_o) == '1));

  assert_roll_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    roll_irq_o |=> !roll_irq_o);

  assert_match_equal_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_irq_o |-> ($past(count_o) == $past(util_i)));

  assert_match_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_irq_o |=> !match_irq_o);
endmodule

bind tt_counter tt_counter_checker #(.CNT_W(CNT_W)) u_tt_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .rate_sel_i      (rate_sel_i),
  .sync_en_i       (sync_en_i),
  .sync_i          (sync_i),
  .sync_data_vld_i (sync_data_vld_i),
  .sync_data_i     (sync_data_i),
  .util_i          (util_i),
  .count_o         (count_o),
  .roll_irq_o      (roll_irq_o),
  .match_irq_o     (match_irq_o)
);

// File: tb/tt_counter_bench.sv
module tt_counter_bench;
  localparam int D = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  rate_sel_i = 3'd6;
  logic        ext_clk_i = 1'b0;
  logic        sync_en_i = 1'b0;
  logic        sync_i = 1'b0;
  logic        sync_data_vld_i = 1'b0;
  logic [15:0] sync_data_i = '0;
  logic [15:0] util_i = '0;
  logic        roll_irq_en_i = 1'b0;
  logic        match_irq_en_i = 1'b0;
  logic [15:0] count_o;
  logic        roll_irq_o;
  logic        match_irq_o;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  tt_counter #(.BASE_DIV(D)) u_tt_counter (
    .clk_i, .rst_ni, .rate_sel_i, .ext_clk_i, .sync_en_i, .sync_i,
    .sync_data_vld_i, .sync_data_i, .util_i, .roll_irq_en_i,
    .match_irq_en_i, .count_o, .roll_irq_o, .match_irq_o
  );

  // reference model
  int          n_edges = 0;
  bit          ext_hist[$] = '{0, 0, 0};
  logic [15:0] m_count = '0;
  bit          m_eq_prev = 1'b1;
  bit          m_roll = 1'b0;
  bit          m_match = 1'b0;

  always @(posedge clk_i) begin
    if (rst_ni) begin
      bit rt, rise, tk, ld, eqn;
      int sel;
      sel = int'(rate_sel_i);
      rt = 1'b0;
      if (sel < 6)
        rt = ((n_edges % D) == D - 1) &&
             (((n_edges / D) % (1 << sel)) == (1 << sel) - 1);
      rise = ext_hist[1] && !ext_hist[2];
      ext_hist.push_front(ext_clk_i);
      void'(ext_hist.pop_back());
      tk = (sel < 6) ? rt : (sel == 7 ? rise : 1'b0);
      ld = sync_en_i && sync_i;
      eqn = (m_count == util_i);
      m_match = match_irq_en_i && eqn && !m_eq_prev;
      m_eq_prev = eqn;
      m_roll = roll_irq_en_i && !ld && tk && (m_count == 16'hFFFF);
      if (ld) m_count = sync_data_vld_i ? sync_data_i : 16'h0;
      else if (tk) m_count = m_count + 16'd1;
      n_edges++;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      check(cur_req, "count_o", int'(count_o), int'(m_count));
      check("R9", "roll_irq_o", int'(roll_irq_o), int'(m_roll));
      check("R10", "match_irq_o", int'(match_irq_o), int'(m_match));
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic sync_cmd(bit vld, logic [15:0] d);
    sync_i = 1'b1; sync_data_vld_i = vld; sync_data_i = d;
    step(1);
    sync_i = 1'b0; sync_data_vld_i = 1'b0;
  endtask

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(1);
    cur_req = "R1";
    check("R1", "count_o after reset", int'(count_o), 0);
    check("R1", "roll_irq_o after reset", int'(roll_irq_o), 0);
    check("R1", "match_irq_o after reset", int'(match_irq_o), 0);

    cur_req = "R2";
    match_irq_en_i = 1'b1;
    roll_irq_en_i = 1'b1;
    for (int k = 0; k < 6; k++) begin
      rate_sel_i = 3'(k);
      util_i = 16'(k * 7 + 3);
      step(300);
    end

    cur_req = "R3";
    rate_sel_i = 3'd6;
    step(40);

    cur_req = "R4";
    rate_sel_i = 3'd7;
    for (int i = 0; i < 20; i++) begin
      ext_clk_i = 1'b1; step(1 + (i % 3));
      ext_clk_i = 1'b0; step(2 + (i % 2));
    end
    step(5);

    cur_req = "R5";
    rate_sel_i = 3'd6;
    sync_en_i = 1'b1;
    sync_cmd(1'b0, 16'hBEEF);
    step(3);

    cur_req = "R6";
    sync_cmd(1'b1, 16'h1234);
    step(3);

    cur_req = "R7";
    rate_sel_i = 3'd0;
    sync_i = 1'b1; sync_data_vld_i = 1'b1; sync_data_i = 16'h00A0;
    step(9);
    sync_i = 1'b0; sync_data_vld_i = 1'b0;
    step(10);

    cur_req = "R8";
    rate_sel_i = 3'd6;
    sync_en_i = 1'b0;
    sync_cmd(1'b1, 16'h5555);
    sync_cmd(1'b0, 16'h0);
    step(3);

    cur_req = "R9";
    sync_en_i = 1'b1;
    sync_cmd(1'b1, 16'hFFF0);
    rate_sel_i = 3'd0;
    step(100);
    roll_irq_en_i = 1'b0;
    sync_cmd(1'b1, 16'hFFF8);
    step(60);
    roll_irq_en_i = 1'b1;
    sync_cmd(1'b1, 16'hFFFF);
    sync_cmd(1'b0, 16'h0);
    step(5);

    cur_req = "R10";
    rate_sel_i = 3'd6;
    util_i = count_o;
    step(10);
    util_i = 16'h0100;
    sync_cmd(1'b1, 16'h00F0);
    rate_sel_i = 3'd0;
    step(120);
    match_irq_en_i = 1'b0;
    util_i = 16'h0120;
    step(80);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired, actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule